// File: doc/BRIEF.md
# Configurable Sinc Watchdog Decimator

This block turns a one-bit sigma-delta bit stream into signed multi-bit samples. Each input bit counts as +1 or -1 and feeds a cascade of running sums. The sums are followed by difference stages that run at the decimated rate. There is no integrator stage after the differences. The block runs without pause while its enable is high. It accepts a bit on each cycle in which the sample strobe is high.

A two-bit order code picks the response. Codes 1 to 3 select a plain sinc filter of that order. Code 0 selects a fast variant made of two cascaded box windows, each twice the oversampling ratio long. A five-bit code sets the oversampling ratio. The first result is held back until the filter has filled, and the wait depends on the order. After the first result, one result follows every ratio's worth of samples. Pulling enable low clears all filter state, so the full first-result wait applies again after re-enable.

Top module: `sinc_wdog_decim`

## Requirements
- R1: The oversampling ratio R equals `osr` + 1 (1 to 32). After the first result, a result is produced on every R-th accepted sample.
- R2: For `ord` = 1, 2 or 3 (order N), each result equals the sum of the last input values weighted by the N-fold convolution of a length-R box of ones.
- R3: For `ord` = 0, each result equals the input weighted by the convolution of two box windows of length 2R.
- R4: For `ord` = 1 to 3, the first result comes on accepted sample number R*N + N + 1 after enable.
- R5: For `ord` = 0, the first result comes on accepted sample number 4R + 3 after enable.
- R6: An input bit of 1 counts as +1 and an input bit of 0 counts as -1. An all-ones stream gives the filter gain, and an all-zeros stream gives its negative.
- R7: While `en` is low, strobes are ignored, no result is produced and all filter state is cleared. A strobe in the same cycle that `en` is low is also ignored. After re-enable the first-result wait applies again.
- R8: `vld` is high for exactly the one cycle after the clock edge that accepted the sample producing the result. Cycles without a strobe produce no `vld`. After reset, `vld` and `res` are 0.
- R9: `res` is a 24-bit two's-complement value, sign-extended for negative results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable; low clears the filter |
| stb | input | 1 | Sample strobe; the bit on `din` is accepted |
| din | input | 1 | Serial sigma-delta data bit |
| ord | input | 2 | Order code: 0 fast variant, 1..3 sinc order |
| osr | input | 5 | Oversampling code; ratio = code + 1 |
| res | output | 24 | Signed filter result |
| vld | output | 1 | One-cycle result pulse |

## Verification
Two events can fall in the same cycle: a sample strobe and the clear caused by a low enable. The bench ends every configuration by dropping enable in the same cycle that it presents a strobe. The bench then expects no result pulse. It expects the next configuration to rebuild from zero, with the exact first-result latency and exact values. Every order code is run against all 32 ratios, using random, all-ones and all-zeros streams. Each result is compared with a convolution that the bench computes itself.

// File: rtl/sinc_wdog_decim.sv
module sinc_wdog_decim #(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 stb,
  input  logic                 din,
  input  logic [1:0]           ord,
  input  logic [4:0]           osr,
  output logic signed [DW-1:0] res,
  output logic                 vld
);
  localparam int NS = 3;

  logic        [5:0]    r;
  logic                 fast;
  logic        [1:0]    nst;
  logic        [CW-1:0] first_len;
  logic        [5:0]    ph0;
  logic        [5:0]    ph;
  logic        [CW-1:0] cnt, cnt_n;
  logic signed [DW-1:0] x;
  logic signed [DW-1:0] ig  [NS];
  logic signed [DW-1:0] ign [NS];
  logic signed [DW-1:0] d1  [NS];
  logic signed [DW-1:0] d2  [NS];
  logic signed [DW-1:0] c   [NS+1];

  assign r     = {1'b0, osr} + 6'd1;
  assign fast  = (ord == 2'd0);
  assign nst   = fast ? 2'd2 : ord;
  assign x     = din ? DW'(1) : '1;
  assign cnt_n = (cnt == '1) ? cnt : cnt + 1'b1;

  always_comb begin
    int f;
    logic [5:0] rem;
    if (fast) f = 4 * int'(r) + 3;
    else      f = int'(r) * int'(nst) + int'(nst) + 1;
    first_len = CW'(f);
    rem = fast ? 6'd2 : {4'd0, nst};
    for (int i = 0; i < 3; i++)
      if (rem >= r) rem = rem - r;
    ph0 = rem + 6'd1;
  end

  always_comb begin
    ign[0] = ig[0] + x;
    for (int i = 1; i < NS; i++) ign[i] = ig[i] + ign[i-1];
    c[0] = ign[int'(nst) - 1];
    for (int i = 0; i < NS; i++) begin
      if (i < int'(nst)) c[i+1] = c[i] - (fast ? d2[i] : d1[i]);
      else               c[i+1] = c[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      res <= '0;
      ph  <= 6'd1;
      cnt <= '0;
      for (int i = 0; i < NS; i++) begin
        ig[i] <= '0; d1[i] <= '0; d2[i] <= '0;
      end
    end else if (!en) begin
      vld <= 1'b0;
      res <= '0;
      ph  <= ph0;
      cnt <= '0;
      for (int i = 0; i < NS; i++) begin
        ig[i] <= '0; d1[i] <= '0; d2[i] <= '0;
      end
    end else begin
      vld <= 1'b0;
      if (stb) begin
        cnt <= cnt_n;
        for (int i = 0; i < NS; i++) ig[i] <= ign[i];
        if (ph == 6'd1) begin
          ph <= r;
          for (int i = 0; i < NS; i++) begin
            d1[i] <= c[i];
            d2[i] <= d1[i];
          end
          if (cnt_n >= first_len) begin
            vld <= 1'b1;
            res <= c[NS];
          end
        end else begin
          ph <= ph - 6'd1;
        end
      end
    end
  end

  a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(stb && en));
  a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld);
  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && ig[0] == '0 && d1[0] == '0));
  a_r4_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> cnt >= first_len);
  a_r1_phase_reload: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ph == r);
endmodule

// File: tb/tb_sinc_wdog_decim.sv
module tb_sinc_wdog_decim;
  logic clk = 0, rst_n = 0, en = 0, stb = 0, din = 0;
  logic [1:0] ord = 0;
  logic [4:0] osr = 0;
  logic signed [23:0] res;
  logic vld;
  int total = 0, bad = 0;
  int hist [0:511];
  int h [0:255];
  int hlen, k, rr, nn, ff;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sinc_wdog_decim dut (.clk, .rst_n, .en, .stb, .din, .ord, .osr, .res, .vld);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d (ord=%0d osr=%0d k=%0d)", rq, act, exp, ord, osr, k);
    end
  endtask

  task automatic build_h(input int len, input int n);
    int tmp [0:255];
    h[0] = 1; hlen = 1;
    for (int s = 0; s < n; s++) begin
      for (int j = 0; j < hlen + len - 1; j++) begin
        tmp[j] = 0;
        for (int t = 0; t < len; t++)
          if (j - t >= 0 && j - t < hlen) tmp[j] += h[j-t];
      end
      hlen = hlen + len - 1;
      for (int j = 0; j < hlen; j++) h[j] = tmp[j];
    end
  endtask

  function automatic int expect_val(input int kk);
    int s = 0;
    for (int j = 0; j < hlen; j++)
      if (kk - j >= 1) s += h[j] * hist[kk-j];
    return s;
  endfunction

  task automatic step(input bit b, input bit keep_en);
    @(negedge clk);
    chk(!vld, "R8 idle", int'(vld), 0);
    din = b; stb = 1; en = keep_en;
    if (keep_en) begin k++; hist[k] = b ? 1 : -1; end
    @(negedge clk);
    stb = 0;
    if (!keep_en) chk(!vld, "R7 strobe with enable low", int'(vld), 0);
    else begin
      bit ev = (k >= ff) && ((k - ff) % rr == 0);
      if (ord == 0) chk(vld == ev, k < ff ? "R5 latency" : "R1 rate", int'(vld), int'(ev));
      else          chk(vld == ev, k < ff ? "R4 latency" : "R1 rate", int'(vld), int'(ev));
      if (ev && vld) begin
        int e = expect_val(k);
        if (ord == 0) chk($signed(res) == e, "R3 value", int'($signed(res)), e);
        else          chk($signed(res) == e, "R2 value", int'($signed(res)), e);
        if (e < 0) chk(res[23] == 1'b1, "R9 sign", int'(res[23]), 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!vld && res == 0, "R8 reset", int'(vld), 0);
    rst_n = 1;
    for (int o = 0; o < 4; o++) begin
      for (int q = 0; q < 32; q++) begin
        int pat = q % 3;
        @(negedge clk);
        en = 0; ord = 2'(o); osr = 5'(q);
        rr = q + 1;
        nn = (o == 0) ? 2 : o;
        ff = (o == 0) ? 4 * rr + 3 : rr * nn + nn + 1;
        build_h((o == 0) ? 2 * rr : rr, nn);
        k = 0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        en = 1;
        for (int s = 0; s < ff + 3 * rr; s++) begin
          bit b;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          b = (pat == 0) ? lfsr[0] : (pat == 1);
          step(b, 1'b1);
          if (pat == 1 && k == ff)
            chk($signed(res) == ((o == 0) ? 4 * rr * rr : rr ** nn), "R6 ones gain",
                int'($signed(res)), (o == 0) ? 4 * rr * rr : rr ** nn);
          if (pat == 2 && k == ff)
            chk($signed(res) == -((o == 0) ? 4 * rr * rr : rr ** nn), "R6 zeros gain",
                int'($signed(res)), -((o == 0) ? 4 * rr * rr : rr ** nn));
        end
        step(1'b1, 1'b0);
      end
    end
    @(negedge clk);
    chk(!vld, "R7 final idle", int'(vld), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule